// File: doc/BRIEF.md
# Banked Performance Event Counter File

This block holds a set of free-running event counters, each up to 64 bits wide, and exposes them through a narrow window of sixteen register slots. A 2-bit bank value held in a separate select register picks which group of sixteen counters the window currently shows. The slot inside the window comes from the access encoding itself. Together they form a 6-bit counter number, so up to 64 counters can be reached. A second field of the same select register names the monitor instance being addressed. Only accesses aimed at this instance's own identifier reach its counters.

Counters whose number is at or above the implemented count read as zero, and writes to them are dropped. Each counter keeps only the implemented number of low bits, and reads return the upper bits as zero. Each counter has an enable and an event input. While both are high it advances by one per clock and wraps at its implemented width. A software write in the same cycle takes precedence over the increment. Reads are registered and return one clock after the access.

Top module: `evcnt_bank_file`

## Requirements
- R1: After reset every counter holds zero, `rd_valid` is 0 and `rd_data` is 0.
- R2: An access is taken only when `acc_op0`=2, `acc_op1`=3, `acc_crn`=14 and `acc_crm[3:1]`=0. Any other encoding changes no counter and leaves `rd_valid` low in the next cycle.
- R3: The counter addressed is `sel_bank`*16 + {`acc_crm[0]`, `acc_op2`}, where `acc_crm[0]` is bit 3 of the slot number and `acc_op2` supplies bits 2:0.
- R4: A write loads bits [CNT_W-1:0] of `acc_wdata` into the addressed counter in one clock. Bits at or above CNT_W are dropped.
- R5: A read access produces `rd_valid`=1 in the following cycle, with `rd_data` equal to the counter value before the access edge, zero-extended from CNT_W bits. In any cycle without `rd_valid`, `rd_data` is 0.
- R6: A counter number at or above NUM_CNT reads as zero, and a write to it changes no counter.
- R7: When `sel_mon` differs from MON_ID, a read returns zero and a write changes no counter.
- R8: While `cnt_en[i]` and `cnt_evt[i]` are both high, counter i advances by one per clock, modulo 2^CNT_W.
- R9: When a write and an increment hit the same counter in the same cycle, the written value is stored and the increment is lost.
- R10: While `cnt_en[i]` is low, counter i holds its value whatever `cnt_evt[i]` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field, must be 2 |
| acc_op1 | input | 3 | Encoding field, must be 3 |
| acc_crn | input | 4 | Encoding field, must be 14 |
| acc_crm | input | 4 | Encoding field; [3:1] must be 0, [0] is slot bit 3 |
| acc_op2 | input | 3 | Slot bits 2:0 |
| acc_wdata | input | 64 | Write data |
| sel_bank | input | 2 | Bank from the select register |
| sel_mon | input | MON_W | Monitor instance from the select register |
| cnt_en | input | NUM_CNT | Per-counter enable |
| cnt_evt | input | NUM_CNT | Per-counter event strobe |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data, zero-extended |

## Verification
A read result is due exactly one clock after the edge that takes the access. It reflects the counter value before that edge. A write or an increment takes effect at that same edge and becomes visible through the read of the next access. The bench drives every input just after the falling edge and samples the outputs 1 ns after the rising edge. Before each rising edge, a behavioural model computes the outputs due at that edge from its pre-edge counter values, then moves its counters forward by that cycle's writes and increments. Because the model and the design step together, every comparison refers to one known cycle.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int DATA_W   = 64;
  localparam int BANK_W   = 2;
  localparam int SLOT_W   = 4;
  localparam int NUM_W    = BANK_W + SLOT_W;
  localparam logic [1:0] ENC_OP0 = 2'd2;
  localparam logic [2:0] ENC_OP1 = 3'd3;
  localparam logic [3:0] ENC_CRN = 4'd14;

  typedef struct packed {
    logic             hit;
    logic             wr;
    logic [NUM_W-1:0] num;
  } evcnt_req_t;
endpackage

// File: rtl/evcnt_decode.sv
module evcnt_decode
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 40,
  parameter int MON_W   = 2,
  parameter int MON_ID  = 1
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_op0,
  input  logic [2:0]        acc_op1,
  input  logic [3:0]        acc_crn,
  input  logic [3:0]        acc_crm,
  input  logic [2:0]        acc_op2,
  input  logic [BANK_W-1:0] sel_bank,
  input  logic [MON_W-1:0]  sel_mon,
  output evcnt_req_t        req,
  output logic [NUM_CNT-1:0] sel
);
  logic enc_ok;
  logic owned;

  always_comb begin
    enc_ok   = (acc_op0 == ENC_OP0) && (acc_op1 == ENC_OP1) &&
               (acc_crn == ENC_CRN) && (acc_crm[3:1] == 3'b000);
    req.hit  = acc_valid && enc_ok;
    req.wr   = acc_write;
    req.num  = {sel_bank, acc_crm[0], acc_op2};
    owned    = (sel_mon == MON_W'(MON_ID)) &&
               ({1'b0, req.num} < (NUM_W+1)'(NUM_CNT));
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
    assign sel[i] = req.hit && owned && (req.num == NUM_W'(i));
  end
endmodule

// File: rtl/evcnt_cell.sv
module evcnt_cell #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             en,
  input  logic             evt,
  output logic [CNT_W-1:0] q
);
  logic [CNT_W-1:0] q_nxt;
  logic             ce;

  always_comb begin
    ce    = ld || (en && evt);
    q_nxt = ld ? ld_val : (q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= q_nxt;
  end
endmodule

// File: rtl/evcnt_rdport.sv
module evcnt_rdport
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 40,
  parameter int CNT_W   = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_req,
  input  logic [NUM_CNT-1:0]       sel,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data
);
  logic [CNT_W-1:0]  or_tree [NUM_CNT+1];
  logic [DATA_W-1:0] data_nxt;

  assign or_tree[0] = '0;
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_or
    assign or_tree[i+1] = or_tree[i] |
                          ({CNT_W{sel[i]}} & cnt_flat[i*CNT_W +: CNT_W]);
  end

  always_comb begin
    data_nxt = '0;
    if (rd_req) data_nxt[CNT_W-1:0] = or_tree[NUM_CNT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= data_nxt;
    end
  end
endmodule

// File: rtl/evcnt_bank_file.sv
module evcnt_bank_file
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 40,
  parameter int CNT_W   = 48,
  parameter int MON_W   = 2,
  parameter int MON_ID  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [1:0]         acc_op0,
  input  logic [2:0]         acc_op1,
  input  logic [3:0]         acc_crn,
  input  logic [3:0]         acc_crm,
  input  logic [2:0]         acc_op2,
  input  logic [63:0]        acc_wdata,
  input  logic [1:0]         sel_bank,
  input  logic [MON_W-1:0]   sel_mon,
  input  logic [NUM_CNT-1:0] cnt_en,
  input  logic [NUM_CNT-1:0] cnt_evt,
  output logic               rd_valid,
  output logic [63:0]        rd_data
);
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  evcnt_req_t               req;
  logic [NUM_CNT-1:0]       sel;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic                     rd_req;

  evcnt_decode #(
    .NUM_CNT (NUM_CNT),
    .MON_W   (MON_W),
    .MON_ID  (MON_ID)
  ) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_op0   (acc_op0),
    .acc_op1   (acc_op1),
    .acc_crn   (acc_crn),
    .acc_crm   (acc_crm),
    .acc_op2   (acc_op2),
    .sel_bank  (sel_bank),
    .sel_mon   (sel_mon),
    .req       (req),
    .sel       (sel)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    evcnt_cell #(.CNT_W(CNT_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .ld     (sel[i] && req.wr),
      .ld_val (acc_wdata[CNT_W-1:0]),
      .en     (cnt_en[i]),
      .evt    (cnt_evt[i]),
      .q      (cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  if (CNT_W < 64) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^acc_wdata[63:CNT_W];
  end

  assign rd_req = req.hit && !req.wr;

  evcnt_rdport #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
  ) u_rdport (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_req   (rd_req),
    .sel      (sel),
    .cnt_flat (cnt_flat),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/evcnt_bank_file_chk.sv
module evcnt_bank_file_chk #(
  parameter int NUM_CNT = 40,
  parameter int CNT_W   = 48,
  parameter int MON_W   = 2,
  parameter int MON_ID  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [1:0]       acc_op0,
  input logic [2:0]       acc_op1,
  input logic [3:0]       acc_crn,
  input logic [3:0]       acc_crm,
  input logic [2:0]       acc_op2,
  input logic [1:0]       sel_bank,
  input logic [MON_W-1:0] sel_mon,
  input logic             rd_valid,
  input logic [63:0]      rd_data
);
  logic       enc_rd;
  logic [6:0] num;

  assign enc_rd = acc_valid && !acc_write && acc_op0 == 2'd2 && acc_op1 == 3'd3 &&
                  acc_crn == 4'd14 && acc_crm[3:1] == 3'b000;
  assign num    = {1'b0, sel_bank, acc_crm[0], acc_op2};

  p_read_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enc_rd |=> rd_valid);

  p_no_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_rd |=> !rd_valid);

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 64'd0);

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> CNT_W) == 64'd0);

  p_raz_num_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_rd && num >= 7'(NUM_CNT)) |=> rd_data == 64'd0);

  p_raz_mon_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_rd && sel_mon != MON_W'(MON_ID)) |=> rd_data == 64'd0);
endmodule

bind evcnt_bank_file evcnt_bank_file_chk #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W),
  .MON_W   (MON_W),
  .MON_ID  (MON_ID)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_op0   (acc_op0),
  .acc_op1   (acc_op1),
  .acc_crn   (acc_crn),
  .acc_crm   (acc_crm),
  .acc_op2   (acc_op2),
  .sel_bank  (sel_bank),
  .sel_mon   (sel_mon),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data)
);

// File: tb/evcnt_bank_file_tb_top.sv
`timescale 1ns/1ps
module evcnt_bank_file_tb_top;
  localparam int NUM = 40;
  localparam int W   = 48;
  localparam int MID = 1;
  localparam logic [63:0] MASK = (64'd1 << W) - 64'd1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           acc_valid, acc_write;
  logic [1:0]     acc_op0;
  logic [2:0]     acc_op1;
  logic [3:0]     acc_crn, acc_crm;
  logic [2:0]     acc_op2;
  logic [63:0]    acc_wdata;
  logic [1:0]     sel_bank, sel_mon;
  logic [NUM-1:0] cnt_en, cnt_evt;
  logic           rd_valid;
  logic [63:0]    rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [63:0] mdl [NUM];

  always #2 clk = ~clk;

  evcnt_bank_file #(.NUM_CNT(NUM), .CNT_W(W), .MON_W(2), .MON_ID(MID)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm),
    .acc_op2(acc_op2), .acc_wdata(acc_wdata), .sel_bank(sel_bank), .sel_mon(sel_mon),
    .cnt_en(cnt_en), .cnt_evt(cnt_evt), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive after falling edge, model predicts, compare after rising edge
  task automatic step(string tag, bit v, bit w, logic [1:0] bank, logic [1:0] mon,
                      logic [1:0] op0, logic [2:0] op1, logic [3:0] crn,
                      logic [3:0] crm, logic [2:0] op2, logic [63:0] wd);
    logic [63:0] nxt [NUM];
    bit   enc, own, rv;
    int   num;
    logic [63:0] rd;
    @(negedge clk);
    acc_valid = v; acc_write = w; sel_bank = bank; sel_mon = mon;
    acc_op0 = op0; acc_op1 = op1; acc_crn = crn; acc_crm = crm; acc_op2 = op2;
    acc_wdata = wd;
    enc = v && op0 == 2 && op1 == 3 && crn == 14 && crm[3:1] == 0;
    num = bank * 16 + crm[0] * 8 + op2;
    own = (mon == MID) && (num < NUM);
    rv  = enc && !w;
    rd  = (rv && own) ? mdl[num] : 64'd0;
    for (int i = 0; i < NUM; i++) begin
      nxt[i] = mdl[i];
      if (cnt_en[i] && cnt_evt[i]) nxt[i] = (mdl[i] + 64'd1) & MASK;
      if (enc && w && own && i == num) nxt[i] = wd & MASK;
    end
    @(posedge clk);
    #1;
    check({tag, " rd_valid"}, {63'd0, rd_valid}, {63'd0, rv});
    check({tag, " rd_data"}, rd_data, rd);
    for (int i = 0; i < NUM; i++) mdl[i] = nxt[i];
  endtask

  task automatic wr(string tag, int num, logic [63:0] d, logic [1:0] mon = 2'(MID));
    step(tag, 1, 1, 2'(num / 16), mon, 2, 3, 14, {3'b0, 1'((num / 8) % 2)}, 3'(num % 8), d);
  endtask

  task automatic rd(string tag, int num, logic [1:0] mon = 2'(MID));
    step(tag, 1, 0, 2'(num / 16), mon, 2, 3, 14, {3'b0, 1'((num / 8) % 2)}, 3'(num % 8), 64'd0);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 2'(MID), 0, 0, 0, 0, 0, 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM; i++) mdl[i] = 64'd0;
    rst_n = 1'b0;
    acc_valid = 0; acc_write = 0; acc_op0 = 0; acc_op1 = 0; acc_crn = 0;
    acc_crm = 0; acc_op2 = 0; acc_wdata = 0; sel_bank = 0; sel_mon = 0;
    cnt_en = '0; cnt_evt = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 rd_valid in reset", {63'd0, rd_valid}, 64'd0);
    check("R1 rd_data in reset", rd_data, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) idle("R1 idle");
    rd("R1 counter 0", 0);
    rd("R1 counter 39", 39);

    // R4 upper bits dropped, R5 zero-extended readback
    wr("R4 write 5", 5, 64'hFFFF_1234_5678_9ABC);
    rd("R5 read 5", 5);
    // R3 bank and slot composition
    wr("R3 write 25", 25, 64'h0000_0000_0000_0A25);
    wr("R3 write 35", 35, 64'h0000_0000_0000_0B35);
    wr("R3 write 8", 8, 64'h0000_0000_0000_0C08);
    rd("R3 read 25", 25);
    rd("R3 read 35", 35);
    rd("R3 read 9", 9);
    rd("R3 read 8", 8);
    rd("R3 read 0", 0);
    // R6 unimplemented numbers
    wr("R6 write 45", 45, 64'h1234);
    wr("R6 write 63", 63, 64'h5678);
    rd("R6 read 45", 45);
    rd("R6 read 63", 63);
    rd("R6 read 5 intact", 5);
    // R7 other monitor
    wr("R7 write 5 foreign", 5, 64'h77, 2'd2);
    rd("R7 read 5 foreign", 5, 2'd0);
    rd("R7 read 5 own", 5);
    // R2 bad encodings
    step("R2 bad op0 write", 1, 1, 0, 2'(MID), 1, 3, 14, 0, 5, 64'h99);
    step("R2 bad crm write", 1, 1, 0, 2'(MID), 2, 3, 14, 4'b0010, 5, 64'h99);
    step("R2 bad crn read", 1, 0, 0, 2'(MID), 2, 3, 13, 0, 5, 64'd0);
    step("R2 bad op1 read", 1, 0, 0, 2'(MID), 2, 2, 14, 0, 5, 64'd0);
    rd("R2 read 5 intact", 5);

    // R8 counting with a gapped event pattern
    cnt_en[7] = 1'b1;
    for (int k = 0; k < 12; k++) begin
      cnt_evt[7] = (k % 3) != 0;
      idle("R8 count");
    end
    cnt_evt[7] = 1'b0;
    rd("R8 read 7", 7);
    // R8 wrap at implemented width
    wr("R8 preset 7", 7, MASK - 64'd1);
    cnt_evt[7] = 1'b1;
    idle("R8 near wrap");
    idle("R8 wrap");
    cnt_evt[7] = 1'b0;
    rd("R8 read wrapped 7", 7);
    cnt_en[7] = 1'b0;

    // R9 write wins over increment
    cnt_en[8] = 1'b1; cnt_evt[8] = 1'b1;
    wr("R9 write during count", 8, 64'd100);
    cnt_evt[8] = 1'b0;
    rd("R9 read 8", 8);
    cnt_en[8] = 1'b0;

    // R10 disabled counter holds
    wr("R10 preset 9", 9, 64'd55);
    cnt_evt[9] = 1'b1;
    repeat (5) idle("R10 events");
    rd("R10 read 9", 9);
    cnt_evt[9] = 1'b0;

    // several counters counting at once, read while counting
    cnt_en[0] = 1'b1; cnt_evt[0] = 1'b1; cnt_en[39] = 1'b1; cnt_evt[39] = 1'b1;
    repeat (3) idle("R8 multi");
    rd("R8 read 0 live", 0);
    rd("R8 read 39 live", 39);
    cnt_evt = '0; cnt_en = '0;
    idle("R5 tail");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule